// File: doc/BRIEF.md
# Multi-Lane Deskew and Frame Reassembly

This block sits at the receive end of a transport interface whose frames are spread across several parallel byte lanes. The transmitter cuts each frame into fixed-size chunks and deals them round-robin across the lanes. The starting lane advances by one every frame, so the chunk that holds the alignment bytes visits every lane in turn. The sixth byte of each frame does not carry its normal overhead value. It carries a marker that counts frames modulo a fixed period.

Each physical input lane is first aligned on its own. Its aligner hunts for the alignment pattern at chunk boundaries, reads the marker, and locks once the pattern returns exactly one lane-count of frames later with the marker that was predicted. The marker seen at alignment time, taken modulo the lane count, names the logical lane, so the physical wiring order does not matter. Each lane starts writing its own FIFO at the first frame whose marker is zero. This puts every lane's buffer on the same frame. A shared read sequencer then pulls the chunks back in rotated order, one byte per cycle. It rewrites the marker byte to 0x28 and flags byte 1 of each frame.

Top module: `otl_deskew`

## Requirements
- R1: While reset is held and on leaving reset, `outValid`, `outSof` and `skewErr` are all 0.
- R2: A lane locks only when it sees the alignment bytes F6 F6 F6 28 28 at the start of a chunk and sees them again NUM_LANES frames later, followed by the marker value predicted by counting frames from the first sighting.
- R3: A lane's logical identity is the marker byte (frame byte index 5) read with its alignment chunk, modulo NUM_LANES. Any permutation of logical lanes onto physical inputs gives the same output stream.
- R4: Chunk k (0-based, CHUNK_BYTES bytes each) of a frame whose marker is m is taken from logical lane (k + m mod NUM_LANES) mod NUM_LANES. Bytes come out in frame order.
- R5: Output frame byte index 5 is always 0x28, whatever marker value it carried on the lanes.
- R6: `outSof` is high exactly with frame byte index 0. It implies `outValid`. Successive `outSof` pulses are FRAME_CHUNKS*CHUNK_BYTES valid bytes apart.
- R7: Each lane begins buffering at the first frame with marker 0 after it has locked. The output stream begins with byte 0 of that frame, and no byte is emitted before it.
- R8: Inter-lane skew of whole chunks is absorbed as long as no lane FIFO overflows. The output then carries every frame intact and `skewErr` stays 0.
- R9: A write into a full lane FIFO sets `skewErr`. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneValid | input | 1 | All lanes present a byte this cycle |
| laneData | input | NUM_LANES*8 | Physical lane bytes, lane p at bits [8p+7:8p] |
| outByte | output | 8 | Reassembled frame byte |
| outValid | output | 1 | `outByte` holds a frame byte |
| outSof | output | 1 | `outByte` is frame byte index 0 |
| skewErr | output | 1 | Sticky FIFO overflow flag |

## Verification
Corrupt state in one lane usually has a visible effect. A wrong identity, a marker count that is off by one, or a FIFO started on the wrong frame each move whole chunks within a frame or shift the stream by whole frames. The byte-exact comparison therefore catches the fault at the first misplaced chunk, at most one frame after output begins. A sequencer that slips a byte count breaks the start-of-frame spacing and the fixed alignment bytes within one frame period. A FIFO that loses its depth accounting shows up either as a missed or a false `skewErr`, or as a gap in the byte stream.

// File: rtl/otl_deskew_pkg.sv
package otl_deskew_pkg;
  localparam logic [7:0] FAS_BYTE = 8'hF6;
  localparam logic [7:0] OA2_BYTE = 8'h28;

  // strobes from the read sequencer to the datapath
  typedef struct packed {
    logic rdEn;
    logic restore;
    logic sof;
  } rdStrobe_t;

  // expected byte at index idx (0..4) of the alignment chunk
  function automatic logic [7:0] patByte(input logic [2:0] idx);
    return (idx < 3'd3) ? FAS_BYTE : OA2_BYTE;
  endfunction
endpackage

// File: rtl/otl_lane_align.sv
module otl_lane_align
  import otl_deskew_pkg::*;
#(
  parameter int NUM_LANES        = 4,
  parameter int CHUNK_BYTES      = 16,
  parameter int LANE_FRAME_BYTES = 32,
  parameter int MARK_MAX         = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inByte,
  output logic [7:0] laneId,
  output logic       wrEn
);
  localparam int CW = $clog2(CHUNK_BYTES);
  localparam int PW = $clog2(LANE_FRAME_BYTES);
  localparam logic [CW-1:0] CHUNK_LAST = CW'(CHUNK_BYTES - 1);
  localparam logic [PW-1:0] POS_LAST   = PW'(LANE_FRAME_BYTES - 1);
  localparam logic [7:0]    LANES8     = 8'(NUM_LANES);
  localparam logic [7:0]    MARK_LAST  = 8'(MARK_MAX - 1);

  logic          synced, locked, writing;
  logic [CW-1:0] chunkPos;
  logic [PW-1:0] pos;
  logic [2:0]    hunt;
  logic [7:0]    rot, marker;
  logic          fasSlot, startNow;

  // bytes 0..5 of a lane frame that should hold the alignment chunk
  assign fasSlot  = synced && (rot == 8'd0) && (pos < PW'(6));
  assign startNow = locked && !writing && (pos == '0) && (marker == 8'd0);
  assign wrEn     = inValid && (writing || startNow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      synced   <= 1'b0;
      locked   <= 1'b0;
      writing  <= 1'b0;
      chunkPos <= '0;
      pos      <= '0;
      hunt     <= '0;
      rot      <= '0;
      marker   <= '0;
      laneId   <= '0;
    end else if (inValid) begin
      chunkPos <= (chunkPos == CHUNK_LAST) ? '0 : chunkPos + 1'b1;
      if (!synced) begin
        if (hunt == 3'd5) begin
          marker <= inByte;
          laneId <= inByte % LANES8;
          synced <= 1'b1;
          pos    <= PW'(6);
          rot    <= '0;
          hunt   <= '0;
        end else if ((hunt != '0 || chunkPos == '0) && inByte == patByte(hunt)) begin
          hunt <= hunt + 3'd1;
        end else begin
          hunt <= '0;
        end
      end else begin
        if (pos == POS_LAST) begin
          pos    <= '0;
          marker <= (marker == MARK_LAST) ? 8'd0 : marker + 8'd1;
          rot    <= (rot == LANES8 - 8'd1) ? 8'd0 : rot + 8'd1;
        end else begin
          pos <= pos + 1'b1;
        end
        if (startNow) writing <= 1'b1;
        if (fasSlot) begin
          if (pos == PW'(5)) begin
            if (inByte == marker) locked <= 1'b1;
            else begin
              synced  <= 1'b0;
              locked  <= 1'b0;
              writing <= 1'b0;
            end
          end else if (inByte != patByte(pos[2:0])) begin
            synced  <= 1'b0;
            locked  <= 1'b0;
            writing <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/otl_deskew_dp.sv
module otl_deskew_dp
  import otl_deskew_pkg::*;
#(
  parameter int NUM_LANES        = 4,
  parameter int CHUNK_BYTES      = 16,
  parameter int LANE_FRAME_BYTES = 32,
  parameter int MARK_MAX         = 12,
  parameter int DEPTH            = 128
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   laneValid,
  input  logic [NUM_LANES*8-1:0] laneData,
  input  rdStrobe_t              strobe,
  input  logic [7:0]             rdId,
  output logic                   allWriting,
  output logic                   selEmpty,
  output logic [7:0]             outByte,
  output logic                   outValid,
  output logic                   outSof,
  output logic                   skewErr
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [NUM_LANES-1:0]      startedVec, emptyVec, hitVec, ovfVec;
  logic [NUM_LANES-1:0][7:0] headVec;
  logic [7:0]                selData;

  for (genvar p = 0; p < NUM_LANES; p++) begin : g_lane
    logic [7:0]    id;
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          wr, wrOk, rd, full, started;

    otl_lane_align #(
      .NUM_LANES(NUM_LANES), .CHUNK_BYTES(CHUNK_BYTES),
      .LANE_FRAME_BYTES(LANE_FRAME_BYTES), .MARK_MAX(MARK_MAX)
    ) u_align (
      .clk(clk), .rstN(rstN), .inValid(laneValid),
      .inByte(laneData[p*8 +: 8]), .laneId(id), .wrEn(wr)
    );

    assign full          = (cnt == FULL_CNT);
    assign wrOk          = wr && !full;
    assign hitVec[p]     = (id == rdId);
    assign rd            = strobe.rdEn && hitVec[p];
    assign emptyVec[p]   = (cnt == '0);
    assign ovfVec[p]     = wr && full;
    assign headVec[p]    = mem[rp];
    assign startedVec[p] = started;

    always_ff @(posedge clk) begin
      if (wrOk) mem[wp] <= laneData[p*8 +: 8];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wp      <= '0;
        rp      <= '0;
        cnt     <= '0;
        started <= 1'b0;
      end else begin
        if (wr) started <= 1'b1;
        if (wrOk) wp <= wp + 1'b1;
        if (rd)   rp <= rp + 1'b1;
        case ({wrOk, rd})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end
  end

  assign allWriting = &startedVec;

  always_comb begin
    selData  = '0;
    selEmpty = 1'b1;
    for (int p = 0; p < NUM_LANES; p++) begin
      if (hitVec[p]) begin
        selData  = headVec[p];
        selEmpty = emptyVec[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outByte  <= '0;
      outValid <= 1'b0;
      outSof   <= 1'b0;
      skewErr  <= 1'b0;
    end else begin
      outValid <= strobe.rdEn;
      outSof   <= strobe.rdEn && strobe.sof;
      outByte  <= strobe.restore ? OA2_BYTE : selData;
      skewErr  <= skewErr | (|ovfVec);
    end
  end
endmodule

// File: rtl/otl_reasm_ctrl.sv
module otl_reasm_ctrl
  import otl_deskew_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int CHUNK_BYTES  = 16,
  parameter int FRAME_CHUNKS = 8,
  parameter int MARK_MAX     = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       allWriting,
  input  logic       selEmpty,
  output rdStrobe_t  strobe,
  output logic [7:0] rdId
);
  localparam int BW = $clog2(CHUNK_BYTES);
  localparam int KW = $clog2(FRAME_CHUNKS);
  localparam logic [BW-1:0] BYTE_LAST  = BW'(CHUNK_BYTES - 1);
  localparam logic [KW-1:0] CHUNK_LAST = KW'(FRAME_CHUNKS - 1);
  localparam logic [7:0]    LANES8     = 8'(NUM_LANES);
  localparam logic [7:0]    MARK_LAST  = 8'(MARK_MAX - 1);

  logic          running;
  logic [BW-1:0] bIdx;
  logic [KW-1:0] cIdx;
  logic [7:0]    rdMk, rot;

  always_comb begin
    rot            = rdMk % LANES8;
    rdId           = (8'(cIdx) + rot) % LANES8;
    strobe.rdEn    = running && !selEmpty;
    strobe.sof     = (cIdx == '0) && (bIdx == '0);
    strobe.restore = (cIdx == '0) && (bIdx == BW'(5));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      bIdx    <= '0;
      cIdx    <= '0;
      rdMk    <= '0;
    end else begin
      running <= running | allWriting;
      if (strobe.rdEn) begin
        if (bIdx == BYTE_LAST) begin
          bIdx <= '0;
          if (cIdx == CHUNK_LAST) begin
            cIdx <= '0;
            rdMk <= (rdMk == MARK_LAST) ? 8'd0 : rdMk + 8'd1;
          end else begin
            cIdx <= cIdx + 1'b1;
          end
        end else begin
          bIdx <= bIdx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/otl_deskew.sv
module otl_deskew
  import otl_deskew_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int CHUNK_BYTES  = 16,
  parameter int FRAME_CHUNKS = 8,
  parameter int MARK_MAX     = 12,
  parameter int DEPTH        = 128
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   laneValid,
  input  logic [NUM_LANES*8-1:0] laneData,
  output logic [7:0]             outByte,
  output logic                   outValid,
  output logic                   outSof,
  output logic                   skewErr
);
  localparam int LANE_FRAME_BYTES = (FRAME_CHUNKS / NUM_LANES) * CHUNK_BYTES;

  rdStrobe_t  strobe;
  logic [7:0] rdId;
  logic       allWriting, selEmpty;

  otl_reasm_ctrl #(
    .NUM_LANES(NUM_LANES), .CHUNK_BYTES(CHUNK_BYTES),
    .FRAME_CHUNKS(FRAME_CHUNKS), .MARK_MAX(MARK_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .allWriting(allWriting), .selEmpty(selEmpty),
    .strobe(strobe), .rdId(rdId)
  );

  otl_deskew_dp #(
    .NUM_LANES(NUM_LANES), .CHUNK_BYTES(CHUNK_BYTES),
    .LANE_FRAME_BYTES(LANE_FRAME_BYTES), .MARK_MAX(MARK_MAX), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .laneValid(laneValid), .laneData(laneData),
    .strobe(strobe), .rdId(rdId), .allWriting(allWriting), .selEmpty(selEmpty),
    .outByte(outByte), .outValid(outValid), .outSof(outSof), .skewErr(skewErr)
  );
endmodule

// File: rtl/otl_deskew_chk.sv
module otl_deskew_chk #(
  parameter int FRAME_BYTES = 128
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] outByte,
  input logic       outValid,
  input logic       outSof,
  input logic       skewErr
);
  localparam logic [15:0] FRAME16 = 16'(FRAME_BYTES);

  logic [15:0] cnt, curPos;
  logic        seen;

  assign curPos = outSof ? 16'd0 : cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (outValid) begin
      cnt <= curPos + 16'd1;
      if (outSof) seen <= 1'b1;
    end
  end

  p_sof_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid);

  p_sof_period_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && seen && cnt == FRAME16) |-> outSof);

  p_sof_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outSof && seen) |-> (cnt == FRAME16));

  p_restore_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (seen || outSof) && curPos == 16'd5) |-> (outByte == 8'h28));

  p_align_bytes_r4: assert property (@(posedge clk) disable iff (!rstN || skewErr)
    (outValid && (seen || outSof) && curPos < 16'd3) |-> (outByte == 8'hF6));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    skewErr |=> skewErr);
endmodule

bind otl_deskew otl_deskew_chk #(.FRAME_BYTES(FRAME_CHUNKS * CHUNK_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .outByte(outByte), .outValid(outValid),
  .outSof(outSof), .skewErr(skewErr)
);

// File: tb/sim_otl_deskew.sv
`timescale 1ns/1ps
module sim_otl_deskew;
  localparam int N      = 4;
  localparam int CHUNK  = 16;
  localparam int FCH    = 8;
  localparam int MMAX   = 12;
  localparam int DEPTH  = 128;
  localparam int FB     = FCH * CHUNK;
  localparam int LFB    = (FCH / N) * CHUNK;
  // every lane locks within 2*N frames plus skew, so the first common marker-0 frame is MMAX
  localparam int START  = MMAX;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           laneValid = 1'b0;
  logic [N*8-1:0] laneData = '0;
  logic [7:0]     outByte;
  logic           outValid, outSof, skewErr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  otl_deskew #(.NUM_LANES(N), .CHUNK_BYTES(CHUNK), .FRAME_CHUNKS(FCH),
               .MARK_MAX(MMAX), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .laneValid(laneValid), .laneData(laneData),
    .outByte(outByte), .outValid(outValid), .outSof(outSof), .skewErr(skewErr)
  );

  function automatic logic [7:0] frameByte(int f, int i);
    if (i < 3) return 8'hF6;
    if (i < 5) return 8'h28;
    if (i == 5) return 8'(f % MMAX);
    return 8'((f * 7 + i) & 127);
  endfunction

  function automatic logic [7:0] laneByte(int l, int idx);
    int f   = idx / LFB;
    int pos = idx % LFB;
    int r   = (f % MMAX) % N;
    int k   = ((l - r + N) % N) + (pos / CHUNK) * N;
    return frameByte(f, k * CHUNK + pos % CHUNK);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runCase(input int perm[N], input int skew[N], input int frames,
                         input bit expectErr, input string tag);
    int expIdx = 0;
    int step = 0;
    rstN = 1'b0;
    laneValid = 1'b0;
    laneData = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    check(outSof == 1'b0, "R1", "outSof in reset", outSof, 0);
    check(skewErr == 1'b0, "R1", "skewErr in reset", skewErr, 0);
    rstN = 1'b1;
    for (int cyc = 0; cyc < frames * FB; cyc++) begin
      @(negedge clk);
      if (cyc < START * FB)
        check(outValid == 1'b0, "R7", "output before first marker-0 frame", outValid, 0);
      if (!expectErr) begin
        if (outValid) begin
          int pos = expIdx % FB;
          logic [7:0] exp = (pos == 5) ? 8'h28 : frameByte(START + expIdx / FB, pos);
          check(outByte == exp, (pos == 5) ? "R5" : tag, "byte", outByte, exp);
          check(outSof == (pos == 0), "R6", "sof", outSof, (pos == 0));
          expIdx++;
        end
        check(skewErr == 1'b0, "R8", "skewErr within depth", skewErr, 0);
      end
      laneValid = (cyc % N == 0);
      if (cyc % N == 0) begin
        for (int p = 0; p < N; p++) begin
          int idx = step - skew[p];
          laneData[p*8 +: 8] = (idx < 0) ? 8'h00 : laneByte(perm[p], idx);
        end
        step++;
      end
    end
    laneValid = 1'b0;
    @(negedge clk);
    if (expectErr) begin
      check(skewErr == 1'b1, "R9", "skewErr after overflow", skewErr, 1);
      repeat (20) @(negedge clk);
      check(skewErr == 1'b1, "R9", "skewErr sticky", skewErr, 1);
    end else begin
      check(expIdx >= 8 * FB, "R8", "bytes delivered", expIdx, 8 * FB);
    end
  endtask

  initial begin
    int permId[N]  = '{0, 1, 2, 3};
    int permMix[N] = '{2, 0, 3, 1};
    int skew0[N]   = '{0, 0, 0, 0};
    int skewMix[N] = '{0, 32, 16, 48};
    int skewBig[N] = '{0, 0, 192, 0};
    // R2 R4: straight wiring, no skew
    runCase(permId, skew0, 24, 1'b0, "R4");
    // R3: permuted lanes with chunk skew
    runCase(permMix, skewMix, 26, 1'b0, "R3");
    // R9: skew beyond the FIFO depth
    runCase(permId, skewBig, 22, 1'b1, "R9");
    // R1: reset clears the sticky flag
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(skewErr == 1'b0, "R1", "skewErr cleared by reset", skewErr, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule